// File: doc/BRIEF.md
# Banked Flash Command Interface

This block models the command side of a byte-wide parallel flash save memory that a host sees through a 16-bit address window. The host performs single-byte writes, which the block decodes as unlock keys, command bytes or armed operations, and single-byte reads, which return array contents or, in identification mode, a pair of identity bytes. A parameter chooses between a single-bank part and a two-bank part. The two-bank part adds a bank bit that moves every array access to the upper half of the storage.

Every operation finishes in the clock that samples its write strobe: byte program, 4 KB sector erase, whole-array erase and bank switch. Program, sector erase and bank switch work in two steps. A command sequence arms the operation, and a later plain bus write carries it out. Read data is combinational. Busy timing, status polling and write protection are not modelled.

For elaboration, the array keeps address bits 15:12 together with a parameterised number of low offset bits. With the low-bit count set to 12 the full part is modelled. With smaller counts, offsets that differ only in the dropped middle bits alias onto the same byte.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the interface is in the ready state with identification mode off, no operation armed and bank 0 selected, and every array byte reads 0xFF.
- R2: Only address bits 15:0 are used for command decode and array indexing; higher address bits have no effect.
- R3: In ready, writing 0xAA to offset 0x5555 enters the set state. In set, writing 0x55 to offset 0x2AAA enters the command state. In command, the next write to 0x5555 is taken as a command and the interface returns to ready. An unknown command byte changes nothing else.
- R4: Writing 0xF0 to offset 0x5555 while not in the command state returns the interface to ready.
- R5: Command 0x90 turns identification mode on and command 0xF0 turns it off. While it is on, offset 0x0000 reads the manufacturer byte and offset 0x0001 reads the device byte: 0x62 and 0x13 on the two-bank part, 0x32 and 0x1B on the single-bank part. All other offsets read the array.
- R6: Command 0xA0 arms a program. The next write, to any offset, stores its byte at that offset in the current bank and disarms the program. This write overrides every other decode, including unlock and command handling.
- R7: Command 0x80 arms erase. A write of 0x30 in the command state with erase armed, to an offset whose bits 11:0 are zero, fills the 4 KB sector chosen by offset bits 15:12 in the current bank with 0xFF, disarms erase and returns to ready. This rule takes precedence over bank selection and command decode.
- R8: Command 0x10 with erase armed fills the whole array, both banks, with 0xFF and disarms erase. Without erase armed it changes no data.
- R9: Command 0xB0 arms bank selection, which then stays armed. On the two-bank part, each later write to offset 0x0000 loads the bank bit from data bit 0, and the two banks hold separate data. On the single-bank part the bank never changes.
- R10: The array keeps offset bits 15:12 and the low STORE_LOW_W offset bits (default 4). Offsets that differ only in bits 11 down to STORE_LOW_W address the same byte.
- R11: A write that matches no rule, and any cycle without a write strobe, leaves the array and all interface state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one byte per asserted cycle |
| addr | input | HOST_ADDR_W | Host byte address; only bits 15:0 are used |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Combinational read byte for `addr` |

## Verification
Two pairs of functions can act on the same write. A program can be armed while the write lands on an unlock offset carrying an unlock key. The bench arms a program and then writes 0xAA to 0x5555. It checks that the byte was stored and that a following 0x55 and 0x90 do not turn on identification mode. A sector erase can also meet bank selection on offset 0x0000. With bank 1 selected and both bank selection and erase armed, the bench writes 0x30 to 0x0000 in the command state. It then checks that sector 0 of bank 1 reads 0xFF and that bank 1 data is still visible, which shows the bank bit was not reloaded from data bit 0.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int OFF_W      = 16;
  localparam int SECT_SHIFT = 12;
  localparam int SECT_SEL_W = OFF_W - SECT_SHIFT;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_SET   = 2'd1,
    ST_CMD   = 2'd2
  } cmd_state_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic prog;
    logic secErase;
    logic chipErase;
  } flash_strobe_t;

  localparam logic [OFF_W-1:0] OFF_KEY_A = 16'h5555;
  localparam logic [OFF_W-1:0] OFF_KEY_B = 16'h2AAA;
  localparam logic [OFF_W-1:0] OFF_BANK  = 16'h0000;
  localparam logic [OFF_W-1:0] OFF_DEV   = 16'h0001;

  localparam logic [7:0] KEY_A        = 8'hAA;
  localparam logic [7:0] KEY_B        = 8'h55;
  localparam logic [7:0] OP_ID_ENTER  = 8'h90;
  localparam logic [7:0] OP_ID_EXIT   = 8'hF0;
  localparam logic [7:0] OP_ABORT     = 8'hF0;
  localparam logic [7:0] OP_BANK_ARM  = 8'hB0;
  localparam logic [7:0] OP_ERASE_ARM = 8'h80;
  localparam logic [7:0] OP_CHIP      = 8'h10;
  localparam logic [7:0] OP_PROG_ARM  = 8'hA0;
  localparam logic [7:0] OP_SECTOR    = 8'h30;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;

  localparam logic [7:0] MFR_ONE_BANK = 8'h32;
  localparam logic [7:0] DEV_ONE_BANK = 8'h1B;
  localparam logic [7:0] MFR_TWO_BANK = 8'h62;
  localparam logic [7:0] DEV_TWO_BANK = 8'h13;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter bit TWO_BANK = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wrData,
  output cmd_state_e        state,
  output logic              progArmed,
  output logic              eraseArmed,
  output logic              idMode,
  output logic              bankSel,
  output flash_strobe_t     strb
);

  cmd_state_e stateNext;
  logic progNext, eraseNext, idNext, bankArmed, bankArmNext;
  logic bankWr, sectorHit;

  assign sectorHit = (state == ST_CMD) && eraseArmed && (wrData == OP_SECTOR)
                     && (off[SECT_SHIFT-1:0] == '0);

  // priority: armed program, then sector erase, then offset decode
  always_comb begin
    stateNext   = state;
    progNext    = progArmed;
    eraseNext   = eraseArmed;
    idNext      = idMode;
    bankArmNext = bankArmed;
    bankWr      = 1'b0;
    strb        = '0;
    if (wrEn) begin
      if (progArmed) begin
        strb.prog = 1'b1;
        progNext  = 1'b0;
      end else if (sectorHit) begin
        strb.secErase = 1'b1;
        eraseNext     = 1'b0;
        stateNext     = ST_READY;
      end else if (off == OFF_BANK) begin
        bankWr = bankArmed;
      end else if (off == OFF_KEY_A) begin
        if (state == ST_CMD) begin
          stateNext = ST_READY;
          case (wrData)
            OP_ID_ENTER:  idNext      = 1'b1;
            OP_ID_EXIT:   idNext      = 1'b0;
            OP_BANK_ARM:  bankArmNext = 1'b1;
            OP_ERASE_ARM: eraseNext   = 1'b1;
            OP_PROG_ARM:  progNext    = 1'b1;
            OP_CHIP: begin
              if (eraseArmed) begin
                strb.chipErase = 1'b1;
                eraseNext      = 1'b0;
              end
            end
            default: ;
          endcase
        end else if (wrData == KEY_A && state == ST_READY) begin
          stateNext = ST_SET;
        end else if (wrData == OP_ABORT) begin
          stateNext = ST_READY;
        end
      end else if (off == OFF_KEY_B) begin
        if (wrData == KEY_B && state == ST_SET) stateNext = ST_CMD;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_READY;
      progArmed  <= 1'b0;
      eraseArmed <= 1'b0;
      idMode     <= 1'b0;
      bankArmed  <= 1'b0;
    end else begin
      state      <= stateNext;
      progArmed  <= progNext;
      eraseArmed <= eraseNext;
      idMode     <= idNext;
      bankArmed  <= bankArmNext;
    end
  end

  generate
    if (TWO_BANK) begin : g_bankReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       bankSel <= 1'b0;
        else if (bankWr) bankSel <= wrData[0];
      end
    end else begin : g_noBank
      assign bankSel = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter bit TWO_BANK    = 1'b1,
  parameter int STORE_LOW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  flash_strobe_t    strb,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wrData,
  input  logic             bankSel,
  input  logic             idMode,
  output logic [7:0]       rdData
);

  localparam int BANK_W     = TWO_BANK ? 1 : 0;
  localparam int SEL_W      = BANK_W + SECT_SEL_W;
  localparam int IDX_W      = SEL_W + STORE_LOW_W;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int SECT_BYTES = 1 << STORE_LOW_W;
  localparam logic [7:0] MFR_ID = TWO_BANK ? MFR_TWO_BANK : MFR_ONE_BANK;
  localparam logic [7:0] DEV_ID = TWO_BANK ? DEV_TWO_BANK : DEV_ONE_BANK;

  logic [SEL_W-1:0] sectSel;
  logic [IDX_W-1:0] idx;
  logic [7:0]       mem [DEPTH];

  generate
    if (TWO_BANK) begin : g_bankIdx
      assign sectSel = {bankSel, off[OFF_W-1:SECT_SHIFT]};
    end else begin : g_flatIdx
      assign sectSel = off[OFF_W-1:SECT_SHIFT];
    end
  endgenerate

  assign idx = {sectSel, off[STORE_LOW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (strb.chipErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (strb.secErase) begin
      for (int j = 0; j < SECT_BYTES; j++)
        mem[{sectSel, STORE_LOW_W'(j)}] <= ERASED_BYTE;
    end else if (strb.prog) begin
      mem[idx] <= wrData;
    end
  end

  always_comb begin
    rdData = mem[idx];
    if (idMode && off == OFF_BANK)     rdData = MFR_ID;
    else if (idMode && off == OFF_DEV) rdData = DEV_ID;
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter bit TWO_BANK    = 1'b1,
  parameter int HOST_ADDR_W = 32,
  parameter int STORE_LOW_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [HOST_ADDR_W-1:0] addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData
);

  logic [OFF_W-1:0] off;
  logic             unusedAddrHi;
  cmd_state_e       ctlState;
  logic             progArmed, eraseArmed, idMode, bankSel;
  flash_strobe_t    strb;

  assign off          = addr[OFF_W-1:0];
  assign unusedAddrHi = ^addr[HOST_ADDR_W-1:OFF_W];

  flash_cmd_ctrl #(.TWO_BANK(TWO_BANK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .off(off), .wrData(wrData),
    .state(ctlState), .progArmed(progArmed), .eraseArmed(eraseArmed),
    .idMode(idMode), .bankSel(bankSel), .strb(strb)
  );

  flash_cmd_datapath #(.TWO_BANK(TWO_BANK), .STORE_LOW_W(STORE_LOW_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .off(off), .wrData(wrData),
    .bankSel(bankSel), .idMode(idMode), .rdData(rdData)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter bit TWO_BANK = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [OFF_W-1:0] off,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input cmd_state_e       state,
  input logic             progArmed,
  input logic             eraseArmed,
  input logic             idMode,
  input logic             bankSel,
  input flash_strobe_t    strb
);

  localparam logic [7:0] MFR_ID = TWO_BANK ? MFR_TWO_BANK : MFR_ONE_BANK;

  p_unlock_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !progArmed && state == ST_READY && off == OFF_KEY_A && wrData == KEY_A
    |=> state == ST_SET);

  p_cmd_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !progArmed && state == ST_CMD && off == OFF_KEY_A
    |=> state == ST_READY);

  p_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !progArmed && state != ST_CMD && off == OFF_KEY_A && wrData == OP_ABORT
    |=> state == ST_READY);

  p_id_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    idMode && off == OFF_BANK |-> rdData == MFR_ID);

  p_prog_priority_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && progArmed
    |=> !progArmed && state == $past(state) && idMode == $past(idMode)
        && bankSel == $past(bankSel));

  p_sector_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && strb.secErase |=> !eraseArmed && state == ST_READY);

  // R6, R7, R8: one array operation per write
  p_one_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.prog, strb.secErase, strb.chipErase}));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(state) && $stable(idMode) && $stable(bankSel)
              && $stable(progArmed) && $stable(eraseArmed));

endmodule

bind flash_cmd_if flash_cmd_chk #(.TWO_BANK(TWO_BANK)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .off(off), .wrData(wrData),
  .rdData(rdData), .state(ctlState), .progArmed(progArmed),
  .eraseArmed(eraseArmed), .idMode(idMode), .bankSel(bankSel), .strb(strb)
);

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData, rdDataOne;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_if #(.TWO_BANK(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData));

  flash_cmd_if #(.TWO_BANK(1'b0)) u_dutOne (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdDataOne));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [7:0] two, output logic [7:0] one);
    @(negedge clk);
    addr = a;
    #1;
    two = rdData;
    one = rdDataOne;
  endtask

  task automatic unlock();
    wr(32'h5555, 8'hAA);
    wr(32'h2AAA, 8'h55);
  endtask

  task automatic command(input logic [7:0] c);
    unlock();
    wr(32'h5555, c);
  endtask

  task automatic t_reset();
    logic [7:0] a, b;
    rd(32'h0000, a, b); check("R1 reset off 0000", a, 8'hFF); check("R1 reset single", b, 8'hFF);
    rd(32'h7FFF, a, b); check("R1 reset off 7FFF", a, 8'hFF);
  endtask

  task automatic t_ident();
    logic [7:0] a, b;
    command(8'h90);
    rd(32'h0000, a, b); check("R5 mfr two-bank", a, 8'h62); check("R5 mfr single", b, 8'h32);
    rd(32'h0001, a, b); check("R5 dev two-bank", a, 8'h13); check("R5 dev single", b, 8'h1B);
    rd(32'h0002, a, b); check("R5 array in id mode", a, 8'hFF);
    command(8'hF0);
    rd(32'h0000, a, b); check("R5 id exit", a, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] a, b;
    command(8'hA0); wr(32'h3007, 8'h5A);
    rd(32'h3007, a, b); check("R6 program", a, 8'h5A);
    wr(32'h3007, 8'h11);
    rd(32'h3007, a, b); check("R11 unarmed write ignored", a, 8'h5A);
    command(8'hA0); wr(32'hABCD3008, 8'h77);
    rd(32'h00003008, a, b); check("R2 high address bits ignored", a, 8'h77);
    rd(32'h3F07, a, b); check("R10 alias within sector", a, 8'h5A);
  endtask

  task automatic t_progPriority();
    logic [7:0] a, b;
    command(8'hA0);
    wr(32'h5555, 8'hAA);
    wr(32'h2AAA, 8'h55);
    wr(32'h5555, 8'h90);
    rd(32'h0000, a, b); check("R6 program beats unlock", a, 8'hFF);
    rd(32'h5555, a, b); check("R6 byte stored at unlock offset", a, 8'hAA);
  endtask

  task automatic t_abort();
    logic [7:0] a, b;
    wr(32'h5555, 8'hAA);
    wr(32'h5555, 8'hF0);
    wr(32'h2AAA, 8'h55);
    wr(32'h5555, 8'h90);
    rd(32'h0000, a, b); check("R4 abort from set", a, 8'hFF);
  endtask

  task automatic t_unknown();
    logic [7:0] a, b;
    command(8'h77);
    wr(32'h2AAA, 8'h55);
    wr(32'h5555, 8'h90);
    rd(32'h0000, a, b); check("R3 unknown command returns ready", a, 8'hFF);
  endtask

  task automatic t_sector();
    logic [7:0] a, b;
    command(8'hA0); wr(32'h2001, 8'h11);
    command(8'hA0); wr(32'h2002, 8'h22);
    command(8'hA0); wr(32'h4001, 8'h44);
    command(8'h80);
    unlock(); wr(32'h2000, 8'h30);
    rd(32'h2001, a, b); check("R7 sector erased byte 1", a, 8'hFF);
    rd(32'h2002, a, b); check("R7 sector erased byte 2", a, 8'hFF);
    rd(32'h4001, a, b); check("R7 other sector kept", a, 8'h44);
    unlock(); wr(32'h4000, 8'h30);
    rd(32'h4001, a, b); check("R7 erase disarmed", a, 8'h44);
    wr(32'h5555, 8'hF0);
  endtask

  task automatic t_chip();
    logic [7:0] a, b;
    command(8'hA0); wr(32'h6003, 8'h66);
    command(8'h10);
    rd(32'h6003, a, b); check("R8 chip erase needs arm", a, 8'h66);
    command(8'h80); command(8'h10);
    rd(32'h6003, a, b); check("R8 chip erase", a, 8'hFF);
    rd(32'h4001, a, b); check("R8 chip erase other sector", a, 8'hFF);
  endtask

  task automatic t_bank();
    logic [7:0] a, b;
    command(8'hA0); wr(32'h0003, 8'hA3);
    command(8'hB0); wr(32'h0000, 8'h01);
    command(8'hA0); wr(32'h1002, 8'hB1);
    rd(32'h1002, a, b); check("R9 bank 1 program", a, 8'hB1);
    wr(32'h0000, 8'h00);
    rd(32'h1002, a, b); check("R9 bank 0 separate", a, 8'hFF); check("R9 single-bank ignores", b, 8'hB1);
    wr(32'h0000, 8'h01);
    rd(32'h1002, a, b); check("R9 back to bank 1", a, 8'hB1);
  endtask

  task automatic t_eraseVsBank();
    logic [7:0] a, b;
    command(8'hA0); wr(32'h0003, 8'hC3);
    command(8'h80);
    unlock(); wr(32'h0000, 8'h30);
    rd(32'h0003, a, b); check("R7 sector erase wins at 0000", a, 8'hFF);
    rd(32'h1002, a, b); check("R7 bank bit untouched", a, 8'hB1);
    wr(32'h0000, 8'h00);
    rd(32'h0003, a, b); check("R9 bank 0 kept across bank 1 erase", a, 8'hA3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ident();
    t_program();
    t_progPriority();
    t_abort();
    t_unknown();
    t_sector();
    t_chip();
    t_bank();
    t_eraseVsBank();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule